// File: doc/BRIEF.md
# Prioritized Chip-Select Address Decoder

This block turns a 28-bit bus address into one select line. There are eight programmable chip-select banks. Each bank holds a 10-bit start tag and a 4-bit size code. The tag gives the upper address bits of the bank's first byte. The size code sets a power-of-two window from 256 KB up to 64 MB. Banks may overlap each other, the DRAM range and the internal register window. A fixed priority settles every overlap, so at most one target is ever selected.

Software programs a bank through a single-cycle write port that carries a bank index, a tag and a size code. Nothing external marks the register window: it is the fixed top region whose upper address bits equal a parameter tag. A DRAM hit comes in as a plain flag. From reset, bank 0 already covers the lowest 8 MB so that boot code can be fetched. Every other bank is off until software configures it.

Top module: `csd_decode_top`

## Requirements
- R1: After reset, bank 0 has tag 0 and size code 6 (8 MB), so addresses 0x0000000 to 0x07FFFFF select bank 0. Banks 1 to 7 have size code 0 and select nothing.
- R2: A bank with a live size code c matches when address bits [27:17+c] equal tag bits [9:c-1]. Tag bits below c-1 are ignored.
- R3: Size codes 1 to 9 give windows of 2^(17+c) bytes: 1 is 256 KB and 9 is 64 MB. Code 0 disables the bank.
- R4: Size codes 10 to 15 disable the bank, in the same way as code 0.
- R5: An address whose bits [27:16] equal 0xFFF is in the register window. It raises the register select and clears every bank and DRAM select, even when banks or the DRAM flag also cover it.
- R6: When several banks match, only the lowest-numbered one is selected.
- R7: The DRAM select rises only when the DRAM flag is set, the address is valid, and neither a bank nor the register window matches.
- R8: The outputs are registered. They reflect the address presented with addr_valid in the previous cycle. They are all zero after a cycle with addr_valid low, and all zero in reset.
- R9: With cfg_we high, the tag and size code are written to bank cfg_idx at the clock edge. A lookup in that same cycle still uses the old setting. Lookups from the next cycle on use the new one.
- R10: Across sel_reg, sel_dram and sel_bank, at most one bit is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Bank setting write strobe |
| cfg_idx | input | 3 | Bank number to write |
| cfg_tag | input | 10 | Start tag, address bits [27:18] |
| cfg_size | input | 4 | Size code |
| addr_valid | input | 1 | Address qualifier |
| addr | input | 28 | Bus address |
| dram_flag | input | 1 | Address lies in the DRAM range |
| sel_bank | output | 8 | One-hot bank select, registered |
| sel_dram | output | 1 | DRAM select, registered |
| sel_reg | output | 1 | Register window select, registered |

## Verification
The hardest case to reach is a three-way overlap. In that case a lower-numbered bank, a higher-numbered bank, the DRAM flag and sometimes the register window all cover the same address. Ignored low tag bits must also be in play.

Random addresses almost never land on such a spot. The stimulus therefore builds addresses from the tag of a randomly chosen bank, with random low bits. It also asserts the DRAM flag on about half of all lookups. Mixed among these are addresses aimed at the register window.

Directed cases add the remaining corners: stacked identical banks, window edges, illegal size codes, and a write racing a lookup in the same cycle.

// File: rtl/csd_pkg.sv
package csd_pkg;

    localparam int ADDR_W   = 28;
    localparam int BASE_W   = 10;
    localparam int SIZE_W   = 4;
    localparam int BASE_LSB = ADDR_W - BASE_W;
    localparam int MAX_CODE = BASE_W - 1;

    typedef struct packed {
        logic [BASE_W-1:0] tag;
        logic [SIZE_W-1:0] size;
    } bank_cfg_t;

    // a size code selects a window only inside 1..MAX_CODE
    function automatic logic code_live(input logic [SIZE_W-1:0] code);
        return (code != '0) && (int'(code) <= MAX_CODE);
    endfunction

    // tag bits that take part in the compare for a given size code
    function automatic logic [BASE_W-1:0] cmp_mask(input logic [SIZE_W-1:0] code);
        logic [BASE_W-1:0] m;
        m = '0;
        for (int i = 0; i < BASE_W; i++) begin
            m[i] = code_live(code) && (i >= int'(code) - 1);
        end
        return m;
    endfunction

endpackage

// File: rtl/csd_cfg_regs.sv
module csd_cfg_regs
    import csd_pkg::*;
#(
    parameter int                NBANK     = 8,
    parameter int                IDX_W     = 3,
    parameter logic [BASE_W-1:0] BOOT_TAG  = '0,
    parameter logic [SIZE_W-1:0] BOOT_SIZE = 4'd6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [IDX_W-1:0]             idx,
    input  logic [BASE_W-1:0]            tag,
    input  logic [SIZE_W-1:0]            size,
    output bank_cfg_t [NBANK-1:0]        cfg_o
);

    bank_cfg_t [NBANK-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        for (int i = 0; i < NBANK; i++) begin
            if (we && (int'(idx) == i)) begin
                cfg_d[i].tag  = tag;
                cfg_d[i].size = size;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBANK; i++) begin
                cfg_q[i].tag  <= (i == 0) ? BOOT_TAG  : '0;
                cfg_q[i].size <= (i == 0) ? BOOT_SIZE : '0;
            end
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/csd_bank_match.sv
module csd_bank_match
    import csd_pkg::*;
#(
    parameter int NBANK = 8
) (
    input  bank_cfg_t [NBANK-1:0] cfg,
    input  logic [BASE_W-1:0]     addr_tag,
    output logic [NBANK-1:0]      hit
);

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic [BASE_W-1:0] mask;
        logic              live;
        assign mask   = cmp_mask(cfg[g].size);
        assign live   = code_live(cfg[g].size);
        assign hit[g] = live && (((addr_tag ^ cfg[g].tag) & mask) == '0);
    end

endmodule

// File: rtl/csd_prio.sv
module csd_prio #(
    parameter int NBANK = 8
) (
    input  logic [NBANK-1:0] bank_hit,
    input  logic             reg_hit,
    input  logic             dram_hit,
    output logic [NBANK-1:0] pick_bank,
    output logic             pick_dram,
    output logic             pick_reg
);

    logic taken;

    always_comb begin
        pick_bank = '0;
        taken     = reg_hit;
        for (int i = 0; i < NBANK; i++) begin
            if (!taken && bank_hit[i]) begin
                pick_bank[i] = 1'b1;
                taken        = 1'b1;
            end
        end
        pick_reg  = reg_hit;
        pick_dram = dram_hit && !taken;
    end

endmodule

// File: rtl/csd_decode_top.sv
module csd_decode_top
    import csd_pkg::*;
#(
    parameter int                   NBANK     = 8,
    parameter int                   REG_TAG_W = 12,
    parameter logic [REG_TAG_W-1:0] REG_TAG   = 12'hFFF,
    parameter logic [BASE_W-1:0]    BOOT_TAG  = 10'h000,
    parameter logic [SIZE_W-1:0]    BOOT_SIZE = 4'd6
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cfg_we,
    input  logic [(NBANK > 1 ? $clog2(NBANK) : 1)-1:0] cfg_idx,
    input  logic [9:0]                            cfg_tag,
    input  logic [3:0]                            cfg_size,
    input  logic                                  addr_valid,
    input  logic [27:0]                           addr,
    input  logic                                  dram_flag,
    output logic [NBANK-1:0]                      sel_bank,
    output logic                                  sel_dram,
    output logic                                  sel_reg
);

    localparam int IDX_W = (NBANK > 1) ? $clog2(NBANK) : 1;

    typedef struct packed {
        logic [NBANK-1:0] bank;
        logic             dram;
        logic             regs;
    } sel_t;

    bank_cfg_t [NBANK-1:0] cfg;
    logic [NBANK-1:0]      bank_hit;
    logic [NBANK-1:0]      pick_bank;
    logic                  pick_dram;
    logic                  pick_reg;
    logic                  reg_hit;
    logic                  unused_low;
    sel_t                  sel_d, sel_q;

    csd_cfg_regs #(
        .NBANK    (NBANK),
        .IDX_W    (IDX_W),
        .BOOT_TAG (BOOT_TAG),
        .BOOT_SIZE(BOOT_SIZE)
    ) u_cfg (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (cfg_we),
        .idx  (cfg_idx),
        .tag  (cfg_tag),
        .size (cfg_size),
        .cfg_o(cfg)
    );

    csd_bank_match #(.NBANK(NBANK)) u_match (
        .cfg     (cfg),
        .addr_tag(addr[ADDR_W-1:BASE_LSB]),
        .hit     (bank_hit)
    );

    assign reg_hit    = (addr[ADDR_W-1 -: REG_TAG_W] == REG_TAG);
    assign unused_low = ^addr[ADDR_W-REG_TAG_W-1:0];

    csd_prio #(.NBANK(NBANK)) u_prio (
        .bank_hit (bank_hit),
        .reg_hit  (reg_hit),
        .dram_hit (dram_flag),
        .pick_bank(pick_bank),
        .pick_dram(pick_dram),
        .pick_reg (pick_reg)
    );

    always_comb begin
        sel_d = '0;
        if (addr_valid) begin
            sel_d.bank = pick_bank;
            sel_d.dram = pick_dram;
            sel_d.regs = pick_reg;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign sel_bank = sel_q.bank;
    assign sel_dram = sel_q.dram;
    assign sel_reg  = sel_q.regs;

endmodule

// File: rtl/csd_decode_chk.sv
module csd_decode_chk #(
    parameter int                   NBANK     = 8,
    parameter int                   REG_TAG_W = 12,
    parameter logic [REG_TAG_W-1:0] REG_TAG   = 12'hFFF
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 addr_valid,
    input logic [REG_TAG_W-1:0] addr_hi,
    input logic                 dram_flag,
    input logic [NBANK-1:0]     sel_bank,
    input logic                 sel_dram,
    input logic                 sel_reg
);

    // R10: a single target at most
    p_single_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_reg, sel_dram, sel_bank}));

    // R8: idle cycle yields quiet outputs
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |=> (sel_bank == '0 && !sel_dram && !sel_reg));

    // R5: register window always wins
    p_regwin_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && addr_hi == REG_TAG) |=> (sel_reg && sel_bank == '0 && !sel_dram));

    // R7: DRAM select only follows a flagged, valid address
    p_dram_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_dram |-> $past(dram_flag && addr_valid));

    // R8: a bank select needs a valid address one cycle earlier
    p_bank_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_bank != '0) |-> $past(addr_valid));

endmodule

bind csd_decode_top csd_decode_chk #(
    .NBANK    (NBANK),
    .REG_TAG_W(REG_TAG_W),
    .REG_TAG  (REG_TAG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_valid(addr_valid),
    .addr_hi   (addr[27 -: REG_TAG_W]),
    .dram_flag (dram_flag),
    .sel_bank  (sel_bank),
    .sel_dram  (sel_dram),
    .sel_reg   (sel_reg)
);

// File: tb/csd_decode_top_bench.sv
module csd_decode_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [9:0]  cfg_tag = '0;
    logic [3:0]  cfg_size = '0;
    logic        addr_valid = 1'b0;
    logic [27:0] addr = '0;
    logic        dram_flag = 1'b0;
    logic [7:0]  sel_bank;
    logic        sel_dram;
    logic        sel_reg;

    int n_run = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [9:0] m_tag  [8];
    logic [3:0] m_size [8];

    always #10 clk = ~clk;

    csd_decode_top u_csd_decode_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_tag(cfg_tag), .cfg_size(cfg_size), .addr_valid(addr_valid),
        .addr(addr), .dram_flag(dram_flag), .sel_bank(sel_bank),
        .sel_dram(sel_dram), .sel_reg(sel_reg)
    );

    // expected {reg, dram, bank[7:0]}
    function automatic logic [9:0] expect_sel(input logic [27:0] a, input logic d, input logic v);
        logic [9:0] r;
        r = '0;
        if (!v) return r;
        if (a[27:16] == 12'hFFF) begin
            r[9] = 1'b1;
            return r;
        end
        for (int b = 0; b < 8; b++) begin
            int s;
            s = int'(m_size[b]);
            if (s >= 1 && s <= 9) begin
                if ((a >> (17 + s)) == ({m_tag[b], 18'b0} >> (17 + s))) begin
                    r[b] = 1'b1;
                    return r;
                end
            end
        end
        r[8] = d;
        return r;
    endfunction

    task automatic check(input logic [9:0] exp, input string req);
        n_run++;
        if ({sel_reg, sel_dram, sel_bank} !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, {sel_reg, sel_dram, sel_bank}, exp);
        end
    endtask

    task automatic write_bank(input int b, input logic [9:0] t, input logic [3:0] s);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(b); cfg_tag = t; cfg_size = s;
        @(negedge clk);
        cfg_we = 1'b0;
        m_tag[b] = t; m_size[b] = s;
    endtask

    task automatic lookup(input logic [27:0] a, input logic d, input logic v, input string req);
        logic [9:0] e;
        @(negedge clk);
        addr = a; dram_flag = d; addr_valid = v;
        e = expect_sel(a, d, v);
        @(negedge clk);
        addr_valid = 1'b0;
        check(e, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int b = 0; b < 8; b++) begin
            m_tag[b] = '0; m_size[b] = (b == 0) ? 4'd6 : 4'd0;
        end
        repeat (3) @(negedge clk);
        check(10'b0, "R8 reset quiet");
        rst_n = 1'b1;

        // R1 boot window
        lookup(28'h0000000, 1'b0, 1'b1, "R1 boot low");
        lookup(28'h07FFFFF, 1'b0, 1'b1, "R1 boot top");
        lookup(28'h0800000, 1'b0, 1'b1, "R1 above boot");
        lookup(28'h0800000, 1'b1, 1'b1, "R7 dram outside banks");
        lookup(28'h0100000, 1'b1, 1'b1, "R7 bank beats dram");
        lookup(28'h0000000, 1'b1, 1'b0, "R8 invalid quiet");

        // R5 register window over a 64 MB bank
        write_bank(1, 10'h3FF, 4'd9);
        lookup(28'hFFF1234, 1'b1, 1'b1, "R5 reg wins");
        lookup(28'hFFE0000, 1'b1, 1'b1, "R3 64MB bank below reg");
        lookup(28'hC000000, 1'b0, 1'b1, "R3 64MB bank base");

        // R6 stacked banks
        write_bank(3, 10'h080, 4'd2);
        write_bank(2, 10'h080, 4'd2);
        lookup(28'h2000000, 1'b0, 1'b1, "R6 lower bank wins");
        lookup(28'h207FFFF, 1'b0, 1'b1, "R6 512K top");
        lookup(28'h2080000, 1'b0, 1'b1, "R3 512K end miss");

        // R3 smallest window
        write_bank(4, 10'h100, 4'd1);
        lookup(28'h403FFFF, 1'b0, 1'b1, "R3 256K top");
        lookup(28'h4040000, 1'b0, 1'b1, "R3 256K end miss");

        // R2 ignored low tag bits
        write_bank(5, 10'h205, 4'd3);
        lookup(28'h8100000, 1'b0, 1'b1, "R2 low tag ignored");
        lookup(28'h80FFFFF, 1'b0, 1'b1, "R2 below window");

        // R4 illegal size codes
        for (int c = 10; c < 16; c++) begin
            write_bank(6, 10'h1C0, 4'(c));
            lookup(28'h7000000, 1'b0, 1'b1, "R4 illegal code disables");
        end

        // R9 write racing a lookup
        begin
            logic [9:0] e;
            @(negedge clk);
            cfg_we = 1'b1; cfg_idx = 3'd7; cfg_tag = 10'h1C0; cfg_size = 4'd4;
            addr = 28'h7000000; dram_flag = 1'b0; addr_valid = 1'b1;
            e = expect_sel(addr, 1'b0, 1'b1);
            @(negedge clk);
            cfg_we = 1'b0; addr_valid = 1'b0;
            m_tag[7] = 10'h1C0; m_size[7] = 4'd4;
            check(e, "R9 same-cycle old setting");
            lookup(28'h7000000, 1'b0, 1'b1, "R9 new setting used");
        end

        // random mix
        for (int k = 0; k < 3000; k++) begin
            int pick;
            logic [27:0] a;
            if ($urandom % 10 == 0)
                write_bank(int'($urandom % 8), 10'($urandom), 4'($urandom % 16));
            pick = int'($urandom % 8);
            case ($urandom % 4)
                0:       a = 28'($urandom);
                1:       a = {12'hFFF, 16'($urandom)};
                default: a = {m_tag[pick], 18'($urandom)} ^ (28'($urandom % 4) << 18);
            endcase
            lookup(a, 1'($urandom), ($urandom % 8) != 0, "R10 random mix R2 R6");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule